// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching translation descriptors from memory. A request carries the virtual address, the kind of access (read, write or instruction fetch), a process offset and the address of the first-level descriptor. Virtual addresses below 0x0200_0000 are first moved up by the process offset. The walker then reads the first-level descriptor. If that descriptor maps a section or supersection, the walk ends there. Otherwise a second-level descriptor is read, and it maps either a 64 KB page or a 4 KB page.

Each walk ends with a one-cycle `done` pulse. With it the block presents the physical address, the 3-bit permission code and the 4-bit domain. If the walk faulted, it also raises `fault` and gives a packed status word. Permission checking, translation caching and cache effects are handled elsewhere. The memory port issues one read at a time and holds it until the read is acknowledged.

The controller has four states:
- IDLE waits for `req_valid`.
- L1_WAIT holds the first-level read. When the read is acknowledged, it moves to DONE if the descriptor is a section or supersection, and to L2_WAIT otherwise.
- L2_WAIT holds the second-level read and moves to DONE when the read is acknowledged.
- DONE lasts one cycle and always returns to IDLE.

Top module: `pt_walker`

## Requirements
- R1: A virtual address below 0x0200_0000 has `proc_offset` added to it (modulo 2^32) before translation. Addresses at or above that limit pass through unchanged.
- R2: The first read goes to `l1_addr`. While `mem_rd_req` is high and `mem_rd_ack` is low, the request stays high and `mem_rd_addr` does not change.
- R3: A first-level descriptor with bits[1:0]=2 and bit 18 clear is a section. Its result is PA = {desc[31:20], VA[19:0]}, and no second read is made.
- R4: A first-level descriptor with bits[1:0]=2 and bit 18 set is a supersection. Its result is PA = {desc[31:24], VA[23:0]}.
- R5: For a section or supersection, the permission code is {desc[15], desc[11:10]} and execute-never is desc[4]. For every walk, the domain is first-level desc[8:5].
- R6: A first-level descriptor whose type is not 2 causes a second read at {desc[31:10], VA[19:12], 2'b00}.
- R7: A second-level type of 1 gives PA = {desc[31:16], VA[15:0]} with execute-never taken from desc[15]. For every second-level result, the permission code is {desc[9], desc[5:4]}.
- R8: A second-level type of 2 or 3 gives PA = {desc[31:12], VA[11:0]} with execute-never taken from desc[0].
- R9: A second-level type of 0 faults with code 7.
- R10: The access kind is encoded as 0 = read, 1 = write, 2 = fetch. A fetch through an execute-never mapping faults, with code 13 on the first-level path and code 15 on the second-level path. A read or write through the same mapping does not fault.
- R11: On a fault, `fault_status` = code | (domain << 4), with bit 11 also set for a write. On success, `fault_status` is 0.
- R12: `done` is high for exactly one cycle per walk. No memory read is requested while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Starts a walk; sampled in IDLE |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| proc_offset | input | 32 | Offset added to low virtual addresses |
| l1_addr | input | 32 | Address of the first-level descriptor |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Memory read address |
| mem_rd_ack | input | 1 | Read acknowledge; data is valid in this cycle |
| mem_rd_data | input | 32 | Read data |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | The walk faulted (valid with done) |
| pa | output | 32 | Physical address (valid with done when no fault) |
| perm | output | 3 | Permission code |
| domain | output | 4 | Domain from the first-level descriptor |
| fault_status | output | 32 | Packed fault status (valid with done) |

## Verification
If the controller is in the wrong state, the port shows it within one or two cycles. Examples are a second read after a section, a missing second read, a read request raised during DONE, or a `done` held longer than one cycle. If a captured descriptor field or the remapped address is wrong, it shows at the next `done` as a wrong PA, permission code, domain or status nibble. The sweep covers every descriptor type, both section sizes, every execute-never position and all three access kinds, with addresses both below and above the remap limit. The second read address is compared on every walk that reaches the second level.

// File: rtl/walk_pkg.sv
package walk_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_L1_WAIT,
        ST_L2_WAIT,
        ST_DONE
    } walk_state_e;

    localparam logic [3:0] CODE_SECTION = 4'd13;
    localparam logic [3:0] CODE_PAGE    = 4'd15;
    localparam logic [3:0] CODE_XLATE   = 4'd7;
    localparam int         WRITE_FLAG_BIT = 11;
endpackage

// File: rtl/walk_va_remap.sv
module walk_va_remap #(
    parameter int          W     = 32,
    parameter logic [31:0] LIMIT = 32'h0200_0000
) (
    input  logic [W-1:0] va_in,
    input  logic [W-1:0] offset,
    output logic [W-1:0] va_out
);
    always_comb begin
        if (va_in < LIMIT[W-1:0])
            va_out = va_in + offset;
        else
            va_out = va_in;
    end
endmodule

// File: rtl/walk_desc_decode.sv
module walk_desc_decode
    import walk_pkg::*;
(
    input  logic [31:0] desc,
    input  logic        second_level,
    input  logic [31:0] va,
    input  logic [1:0]  kind,
    input  logic [3:0]  dom,
    output logic        is_block,
    output logic [31:0] next_addr,
    output logic [31:0] phys,
    output logic [2:0]  perm_code,
    output logic        fails,
    output logic [31:0] status
);
    logic       xn;
    logic       xlate_fault;
    logic [3:0] code;

    always_comb begin
        is_block    = 1'b0;
        next_addr   = {desc[31:10], va[19:12], 2'b00};
        phys        = '0;
        perm_code   = '0;
        xn          = 1'b0;
        xlate_fault = 1'b0;
        code        = CODE_PAGE;
        if (!second_level) begin
            is_block  = (desc[1:0] == 2'd2);
            perm_code = {desc[15], desc[11:10]};
            xn        = desc[4];
            code      = CODE_SECTION;
            if (desc[18])
                phys = {desc[31:24], va[23:0]};
            else
                phys = {desc[31:20], va[19:0]};
        end else begin
            perm_code = {desc[9], desc[5:4]};
            unique case (desc[1:0])
                2'd0: begin
                    xlate_fault = 1'b1;
                    code        = CODE_XLATE;
                end
                2'd1: begin
                    phys = {desc[31:16], va[15:0]};
                    xn   = desc[15];
                end
                default: begin
                    phys = {desc[31:12], va[11:0]};
                    xn   = desc[0];
                end
            endcase
        end
        fails  = xlate_fault || (xn && (kind == ACC_FETCH));
        status = '0;
        if (fails) begin
            status[3:0] = code;
            status[7:4] = dom;
            status[WRITE_FLAG_BIT] = (kind == ACC_WRITE);
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import walk_pkg::*;
#(
    parameter logic [31:0] REMAP_LIMIT = 32'h0200_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_va,
    input  logic [1:0]  req_kind,
    input  logic [31:0] proc_offset,
    input  logic [31:0] l1_addr,
    output logic        mem_rd_req,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_ack,
    input  logic [31:0] mem_rd_data,
    output logic        done,
    output logic        fault,
    output logic [31:0] pa,
    output logic [2:0]  perm,
    output logic [3:0]  domain,
    output logic [31:0] fault_status
);
    walk_state_e st_q, st_nx;

    logic [31:0] va_q, addr_q, va_mapped;
    logic [1:0]  kind_q;
    logic [3:0]  dom_q, dom_sel;
    logic [31:0] pa_q, status_q;
    logic [2:0]  perm_q;
    logic        fault_q;

    logic        dec_block, dec_fail, in_l2;
    logic [31:0] dec_next, dec_phys, dec_status;
    logic [2:0]  dec_perm;

    walk_va_remap #(.W(WORD_W), .LIMIT(REMAP_LIMIT)) u_remap (
        .va_in  (req_va),
        .offset (proc_offset),
        .va_out (va_mapped)
    );

    assign in_l2   = (st_q == ST_L2_WAIT);
    assign dom_sel = in_l2 ? dom_q : mem_rd_data[8:5];

    walk_desc_decode u_dec (
        .desc         (mem_rd_data),
        .second_level (in_l2),
        .va           (va_q),
        .kind         (kind_q),
        .dom          (dom_sel),
        .is_block     (dec_block),
        .next_addr    (dec_next),
        .phys         (dec_phys),
        .perm_code    (dec_perm),
        .fails        (dec_fail),
        .status       (dec_status)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE:    if (req_valid)  st_nx = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rd_ack) st_nx = dec_block ? ST_DONE : ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rd_ack) st_nx = ST_DONE;
            ST_DONE:                    st_nx = ST_IDLE;
            default:                    st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q     <= '0;
            addr_q   <= '0;
            kind_q   <= ACC_READ;
            dom_q    <= '0;
            pa_q     <= '0;
            perm_q   <= '0;
            fault_q  <= 1'b0;
            status_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (req_valid) begin
                    va_q   <= va_mapped;
                    kind_q <= req_kind;
                    addr_q <= l1_addr;
                end
                ST_L1_WAIT: if (mem_rd_ack) begin
                    dom_q <= mem_rd_data[8:5];
                    if (dec_block) begin
                        pa_q     <= dec_phys;
                        perm_q   <= dec_perm;
                        fault_q  <= dec_fail;
                        status_q <= dec_status;
                    end else begin
                        addr_q <= dec_next;
                    end
                end
                ST_L2_WAIT: if (mem_rd_ack) begin
                    pa_q     <= dec_phys;
                    perm_q   <= dec_perm;
                    fault_q  <= dec_fail;
                    status_q <= dec_status;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_rd_req   = (st_q == ST_L1_WAIT) || (st_q == ST_L2_WAIT);
        mem_rd_addr  = addr_q;
        done         = (st_q == ST_DONE);
        fault        = fault_q;
        pa           = pa_q;
        perm         = perm_q;
        domain       = dom_q;
        fault_status = status_q;
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd_req);

    // R11
    ok_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (fault_status == 32'd0));

    // R9
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (fault_status[3:0] == 4'd7 || fault_status[3:0] == 4'd13
                             || fault_status[3:0] == 4'd15));

    // R11
    dom_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (fault_status[7:4] == domain));
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic [31:0] proc_offset = '0;
    logic [31:0] l1_addr = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        done, fault;
    logic [31:0] pa, fault_status;
    logic [2:0]  perm;
    logic [3:0]  domain;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_kind(req_kind), .proc_offset(proc_offset), .l1_addr(l1_addr),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
        .mem_rd_data(mem_rd_data), .done(done), .fault(fault), .pa(pa), .perm(perm),
        .domain(domain), .fault_status(fault_status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [1:0] kind, input logic [31:0] off,
                        input logic [31:0] l1a, input logic [31:0] d1, input logic [31:0] d2,
                        input int stall);
        logic [31:0] v, e_pa, e_l2, e_st;
        logic [2:0]  e_perm;
        logic [3:0]  e_dom, code;
        logic        sect, xn, e_fault;
        int reads = 0;
        int wait_n = stall;
        bit got = 0;
        // R1 remap model
        v = (va < 32'h0200_0000) ? va + off : va;
        e_dom = d1[8:5];
        sect = (d1[1:0] == 2'd2);
        e_l2 = {d1[31:10], v[19:12], 2'b00};
        e_fault = 1'b0;
        if (sect) begin
            e_pa = d1[18] ? {d1[31:24], v[23:0]} : {d1[31:20], v[19:0]};
            e_perm = {d1[15], d1[11:10]};
            xn = d1[4];
            code = 4'd13;
        end else begin
            e_perm = {d2[9], d2[5:4]};
            code = 4'd15;
            xn = 1'b0;
            e_pa = '0;
            if (d2[1:0] == 2'd0) begin
                e_fault = 1'b1;
                code = 4'd7;
            end else if (d2[1:0] == 2'd1) begin
                e_pa = {d2[31:16], v[15:0]};
                xn = d2[15];
            end else begin
                e_pa = {d2[31:12], v[11:0]};
                xn = d2[0];
            end
        end
        if (xn && kind == 2'd2) e_fault = 1'b1;
        e_st = e_fault ? ({20'd0, (kind == 2'd1), 3'd0, e_dom, code}) : 32'd0;

        @(negedge clk);
        req_va = va; req_kind = kind; proc_offset = off; l1_addr = l1a; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 40 && !got; cyc++) begin
            if (done) begin
                got = 1;
                check("R12 reads", reads, sect ? 1 : 2);
                check("R9/R10 fault", {31'd0, fault}, {31'd0, e_fault});
                check("R11 status", fault_status, e_st);
                check("R5 domain", {28'd0, domain}, {28'd0, e_dom});
                if (!e_fault) begin
                    check(sect ? (d1[18] ? "R4 pa" : "R3 pa") : (d2[1:0] == 1 ? "R7 pa" : "R8 pa"),
                          pa, e_pa);
                    check(sect ? "R5 perm" : "R7 perm", {29'd0, perm}, {29'd0, e_perm});
                end
                @(negedge clk);
                check("R12 done pulse", {31'd0, done}, 32'd0);
            end else if (mem_rd_req && !mem_rd_ack) begin
                if (wait_n > 0) begin
                    wait_n--;
                end else begin
                    reads++;
                    if (reads == 1) check("R2 l1 addr", mem_rd_addr, l1a);
                    else            check("R6 l2 addr", mem_rd_addr, e_l2);
                    mem_rd_ack = 1'b1;
                    mem_rd_data = (reads == 1) ? d1 : d2;
                    wait_n = stall;
                end
                @(negedge clk);
            end else begin
                mem_rd_ack = 1'b0;
                mem_rd_data = 32'hDEAD_BEEF;
                @(negedge clk);
            end
        end
        mem_rd_ack = 1'b0;
        if (!got) check("R12 done seen", 32'd0, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d1, d2, va;
        int n = 0;
        repeat (3) @(negedge clk);
        check("R12 reset done", {31'd0, done}, 32'd0);
        check("R2 reset req", {31'd0, mem_rd_req}, 32'd0);
        rst_n = 1'b1;
        for (int t1 = 0; t1 < 4; t1++)
          for (int sb = 0; sb < 2; sb++)
            for (int xp = 0; xp < 4; xp++)
              for (int t2 = 0; t2 < 4; t2++)
                for (int k = 0; k < 3; k++)
                  for (int lo = 0; lo < 2; lo++) begin
                      n++;
                      d1 = 32'(n) * 32'h9E37_79B1;
                      d1[1:0] = 2'(t1); d1[18] = sb[0]; d1[4] = xp[0];
                      d2 = 32'(n) * 32'h85EB_CA6B;
                      d2[1:0] = 2'(t2); d2[0] = (t2 >= 2) ? xp[0] : d2[0];
                      d2[15] = xp[1];
                      va = 32'(n) * 32'hC2B2_AE35;
                      if (lo == 1) va = va & 32'h01FF_FFFF;
                      else         va = va | 32'h0200_0000;
                      walk(va, 2'(k), 32'h0600_0000 + 32'(n) * 32'h0200_0000,
                           32'h4000_0000 + 32'(n) * 4, d1, d2, n % 3);
                  end
        // R1 wrap of the remapped address
        walk(32'h01FF_FFF0, 2'd0, 32'hFF00_0000, 32'h100, 32'h0000_0002, 32'h0, 0);
        // R10 write with execute-never: no fault, bit 11 only on faults
        walk(32'h1234_5678, 2'd1, 32'h0, 32'h200, 32'hABC0_0012, 32'h0, 1);
        // R11 write with a translation fault sets bit 11
        walk(32'h1234_5678, 2'd1, 32'h0, 32'h300, 32'h5555_01E1, 32'h0, 0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule